// File: doc/BRIEF.md
# Modem Control and Local Loopback Unit

This block keeps the serial port's modem control byte and turns its bits into the active-low handshake outputs of the port (data-terminal-ready, request-to-send and a general-purpose output). It also builds the modem status word that a host reads. The upper nibble of that word holds the current levels of clear-to-send, data-set-ready, ring-indicate and carrier-detect in true (active-high) form. The lower nibble holds sticky change flags. Reading the status clears the flags.

Setting the loopback bit of the control byte turns on a diagnostic mode. The serial output pin rests high and the external handshake outputs rest in their inactive high state. The receiver is fed from the transmitter's serial data, and the four status inputs are sourced from the control bits rather than from the pins. Change detection keeps working in this mode, so software can raise every status flag without any cabling. A control bit that has no pin of its own exists only to drive ring-indicate in this mode.

The external status inputs pass through a synchronizer whose depth is set by a parameter. The loopback sources are already synchronous, so they bypass it.

Top module: `modem_ctl_loop`

## Requirements
- R1: After reset the control byte `ctl_o` is 0x00. A cycle with `ctl_wr` high stores `ctl_wdata` with bit 5 forced to 0, and the new value shows on `ctl_o` after that clock edge. Without a write the byte holds its value.
- R2: Outside loopback, `dtr_n_o` is the inverse of control bit 0 and `rts_n_o` is the inverse of control bit 1.
- R3: Outside loopback, `op2_n_o` is the inverse of control bit 3.
- R4: While control bit 4 (loopback) is 1, `tx_pin_o`, `dtr_n_o`, `rts_n_o` and `op2_n_o` are all 1. Outside loopback, `tx_pin_o` follows `tx_ser_i`.
- R5: `rx_ser_o` equals `tx_ser_i` in loopback and `rx_pin_i` otherwise. No register sits on either path.
- R6: In loopback, the status level bits are sourced as follows, one clock after the control byte changes: bit 4 (CTS) from control bit 1, bit 5 (DSR) from control bit 0, bit 6 (RI) from control bit 2, and bit 7 (CD) from control bit 3.
- R7: Outside loopback, status bits 7..4 equal the inverted levels of `cd_n_i`, `ri_n_i`, `dsr_n_i` and `cts_n_i`. They update SYNC_STAGES+1 clock edges after a pin changes.
- R8: Status bits 0, 1 and 3 set when the CTS, DSR and CD level bits (4, 5 and 7) change in either direction. Once set, they stay set until a read.
- R9: Status bit 2 sets only when the RI level bit (bit 6) falls from 1 to 0. A rise of that bit leaves it unchanged.
- R10: A cycle with `stat_rd` high returns the current status on `stat_o` and clears bits 3..0 at that edge. A change detected in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| stat_rd | input | 1 | Status read strobe (clears change flags) |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| cd_n_i | input | 1 | Carrier-detect pin, active low |
| ri_n_i | input | 1 | Ring-indicate pin, active low |
| tx_ser_i | input | 1 | Serial data from the transmitter |
| rx_pin_i | input | 1 | Serial input pin |
| ctl_o | output | 8 | Stored control byte |
| dtr_n_o | output | 1 | Data-terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| op2_n_o | output | 1 | General-purpose output pin, active low |
| tx_pin_o | output | 1 | Serial output pin |
| rx_ser_o | output | 1 | Serial data to the receiver |
| stat_o | output | 8 | Modem status word |

## Verification
Two things can happen at the same edge: a status read clearing the change flags, and a level change setting one of them. A correct design keeps the newly detected change rather than losing it to the clear. The bench provokes this on purpose in directed steps. It toggles a loopback control bit, or an external pin whose change reaches the detector, in exactly the cycle that `stat_rd` is high. It then expects the relevant flag to read 1 while every other flag reads 0. Random stimulus then mixes reads, pin toggles, control writes and loopback switching, so the collision recurs many times. After every edge each output is compared against a reference model built from the requirements.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int CTL_W   = 8;
   localparam int STAT_W  = 8;
   localparam int MSIG_W  = 4;

   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OP1  = 2;
   localparam int CB_OP2  = 3;
   localparam int CB_LOOP = 4;
   localparam int CB_RSVD = 5;

   // modem signal group, bit 3 = cd, bit 2 = ri, bit 1 = dsr, bit 0 = cts
   typedef struct packed {
      logic cd;
      logic ri;
      logic dsr;
      logic cts;
   } mdm_sig_t;
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
   import mdm_pkg::*;
#(
   parameter int               W         = CTL_W,
   parameter logic [W-1:0]     RSVD_MASK = W'(1) << CB_RSVD
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] ctl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ctl_q <= '0;
      else if (wr_i) ctl_q <= wdata_i & ~RSVD_MASK;
   end

   // R1: the byte changes only on a write
   a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(ctl_q));
endmodule

// File: rtl/mdm_in_sync.sv
module mdm_in_sync #(
   parameter int           W       = 4,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   localparam int MAX_STAGES = 4;

   if (STAGES < 0 || STAGES > MAX_STAGES) begin : g_bad_depth
      $error("mdm_in_sync: STAGES out of range");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= (s == 0) ? d_i : stg[(s == 0) ? 0 : s-1];
         end
      end
      assign q_o = stg[STAGES-1];
   end
endmodule

// File: rtl/mdm_loop_mux.sv
module mdm_loop_mux
   import mdm_pkg::*;
(
   input  logic [CTL_W-1:0] ctl_i,
   input  mdm_sig_t         pin_sync_n_i,
   input  logic             tx_ser_i,
   input  logic             rx_pin_i,
   output logic             dtr_n_o,
   output logic             rts_n_o,
   output logic             op2_n_o,
   output logic             tx_pin_o,
   output logic             rx_ser_o,
   output mdm_sig_t         live_o
);
   logic loop;
   assign loop = ctl_i[CB_LOOP];

   always_comb begin
      if (loop) begin
         dtr_n_o     = 1'b1;
         rts_n_o     = 1'b1;
         op2_n_o     = 1'b1;
         tx_pin_o    = 1'b1;
         rx_ser_o    = tx_ser_i;
         live_o.cts  = ctl_i[CB_RTS];
         live_o.dsr  = ctl_i[CB_DTR];
         live_o.ri   = ctl_i[CB_OP1];
         live_o.cd   = ctl_i[CB_OP2];
      end else begin
         dtr_n_o     = ~ctl_i[CB_DTR];
         rts_n_o     = ~ctl_i[CB_RTS];
         op2_n_o     = ~ctl_i[CB_OP2];
         tx_pin_o    = tx_ser_i;
         rx_ser_o    = rx_pin_i;
         live_o      = ~pin_sync_n_i;
      end
   end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
   import mdm_pkg::*;
#(
   parameter int N = MSIG_W
)(
   input  logic            clk,
   input  logic            rst_n,
   input  mdm_sig_t        live_i,
   input  logic            rd_i,
   output logic [2*N-1:0]  stat_o
);
   localparam int RI_BIT = 2;

   logic [N-1:0] lvl_q, dlt_q, set_v, live_v;

   assign live_v = live_i;

   for (genvar b = 0; b < N; b++) begin : g_det
      if (b == RI_BIT) begin : g_trail
         assign set_v[b] = lvl_q[b] & ~live_v[b];
      end else begin : g_any
         assign set_v[b] = lvl_q[b] ^ live_v[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         dlt_q <= '0;
      end else begin
         lvl_q <= live_v;
         dlt_q <= (rd_i ? '0 : dlt_q) | set_v;
      end
   end

   assign stat_o = {lvl_q, dlt_q};

   // R8: a CTS level change raises its flag at the next edge
   a_r8_cts_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q[0] != live_v[0]) |=> stat_o[0]);
   // R8: flags are sticky without a read
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_i && dlt_q[1]) |=> dlt_q[1]);
   // R9: RI flag rises only after a 1 -> 0 level step
   a_r9_ri_trailing: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dlt_q[RI_BIT]) |-> ($past(lvl_q[RI_BIT]) && !lvl_q[RI_BIT]));
   // R10: a read with no concurrent change leaves all flags clear
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && live_v == lvl_q) |=> (stat_o[N-1:0] == '0));
endmodule

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              stat_rd,
   input  logic              cts_n_i,
   input  logic              dsr_n_i,
   input  logic              cd_n_i,
   input  logic              ri_n_i,
   input  logic              tx_ser_i,
   input  logic              rx_pin_i,
   output logic [CTL_W-1:0]  ctl_o,
   output logic              dtr_n_o,
   output logic              rts_n_o,
   output logic              op2_n_o,
   output logic              tx_pin_o,
   output logic              rx_ser_o,
   output logic [STAT_W-1:0] stat_o
);
   mdm_sig_t pins_n, pins_sync_n, live;

   assign pins_n = '{cd: cd_n_i, ri: ri_n_i, dsr: dsr_n_i, cts: cts_n_i};

   mdm_ctl_reg #(.W(CTL_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .wdata_i(ctl_wdata), .ctl_q(ctl_o));

   mdm_in_sync #(.W(MSIG_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pins_n), .q_o(pins_sync_n));

   mdm_loop_mux u_mux (
      .ctl_i(ctl_o), .pin_sync_n_i(pins_sync_n), .tx_ser_i(tx_ser_i),
      .rx_pin_i(rx_pin_i), .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o),
      .op2_n_o(op2_n_o), .tx_pin_o(tx_pin_o), .rx_ser_o(rx_ser_o),
      .live_o(live));

   mdm_status #(.N(MSIG_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .live_i(live), .rd_i(stat_rd), .stat_o(stat_o));
endmodule

// File: tb/tb_modem_ctl_loop.sv
`timescale 1ns/1ps
module tb_modem_ctl_loop;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0, stat_rd = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic cts_n = 1'b1, dsr_n = 1'b1, cd_n = 1'b1, ri_n = 1'b1;
   logic tx_ser = 1'b1, rx_pin = 1'b1;
   logic [7:0] ctl_o, stat_o;
   logic dtr_n_o, rts_n_o, op2_n_o, tx_pin_o, rx_ser_o;

   int n_cmp = 0, n_bad = 0;

   // reference state
   logic [7:0] m_ctl;
   logic [3:0] m_lvl, m_dlt;
   logic [3:0] m_sp [SS];

   always #2 clk = ~clk;

   modem_ctl_loop #(.SYNC_STAGES(SS)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .stat_rd(stat_rd), .cts_n_i(cts_n), .dsr_n_i(dsr_n), .cd_n_i(cd_n),
      .ri_n_i(ri_n), .tx_ser_i(tx_ser), .rx_pin_i(rx_pin), .ctl_o(ctl_o),
      .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .op2_n_o(op2_n_o),
      .tx_pin_o(tx_pin_o), .rx_ser_o(rx_ser_o), .stat_o(stat_o));

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] live_model();
      if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1]};
      return ~m_sp[SS-1];
   endfunction

   task automatic model_reset();
      m_ctl = '0; m_lvl = '0; m_dlt = '0;
      for (int i = 0; i < SS; i++) m_sp[i] = 4'hF;
   endtask

   task automatic compare_all();
      logic lp;
      lp = m_ctl[4];
      chk("R1 ctl", ctl_o, m_ctl);
      chk("R2 R4 dtr", {7'd0, dtr_n_o}, {7'd0, lp | ~m_ctl[0]});
      chk("R2 R4 rts", {7'd0, rts_n_o}, {7'd0, lp | ~m_ctl[1]});
      chk("R3 R4 op2", {7'd0, op2_n_o}, {7'd0, lp | ~m_ctl[3]});
      chk("R4 txpin", {7'd0, tx_pin_o}, {7'd0, lp | tx_ser});
      chk("R5 rxser", {7'd0, rx_ser_o}, {7'd0, lp ? tx_ser : rx_pin});
      chk("R6 R7 R8 R9 R10 stat", stat_o, {m_lvl, m_dlt});
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic step();
      logic [3:0] lv, setv;
      @(posedge clk);
      lv   = live_model();
      setv = {m_lvl[3] ^ lv[3], m_lvl[2] & ~lv[2], m_lvl[1] ^ lv[1], m_lvl[0] ^ lv[0]};
      m_dlt = (stat_rd ? 4'h0 : m_dlt) | setv;
      m_lvl = lv;
      for (int i = SS-1; i > 0; i--) m_sp[i] = m_sp[i-1];
      m_sp[0] = {cd_n, ri_n, dsr_n, cts_n};
      if (ctl_wr) m_ctl = ctl_wdata & 8'hDF;
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v; step(); ctl_wr = 1'b0;
   endtask

   task automatic rd();
      stat_rd = 1'b1; step(); stat_rd = 1'b0;
   endtask

   initial begin
      #(4ns * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5EED_1234);
      model_reset();
      repeat (3) @(negedge clk);
      compare_all();                       // R1 reset state
      rst_n = 1'b1;
      step();

      // R2 R3: pins follow inverted control bits
      wr(8'h0B); step();
      wr(8'h02); step();
      // R1: reserved bit 5 dropped
      wr(8'hE0); step();
      // R7 R8: external pin changes reach the status after the synchronizer
      wr(8'h00);
      cts_n = 1'b0; repeat (4) step();
      rd(); step();
      cd_n = 1'b0; dsr_n = 1'b0; repeat (4) step(); rd();
      // R9: RI falling true-level sets flag, rising does not
      ri_n = 1'b0; repeat (4) step(); rd(); step();
      ri_n = 1'b1; repeat (4) step(); rd();
      cts_n = 1'b1; dsr_n = 1'b1; cd_n = 1'b1; repeat (4) step(); rd();
      // R4 R5 R6: loopback mapping
      tx_ser = 1'b0; rx_pin = 1'b1;
      wr(8'h10); step(); rd();
      wr(8'h11); step(); wr(8'h13); step(); wr(8'h17); step(); wr(8'h1F); step();
      tx_ser = 1'b1; step(); rd();
      wr(8'h1B); step();                   // R9 RI falls via control bit 2
      // R10: change coincides with the read
      wr(8'h19); rd(); step();
      stat_rd = 1'b1; ctl_wr = 1'b1; ctl_wdata = 8'h11; step();
      stat_rd = 1'b0; ctl_wr = 1'b0; step(); step();
      // leave loopback, pin change lands in a read cycle
      wr(8'h00); rd(); rd();
      cts_n = 1'b0; step(); step(); rd(); step();

      // random mix
      for (int i = 0; i < 4000; i++) begin
         ctl_wr  = ($urandom % 8) == 0;
         ctl_wdata = 8'($urandom);
         stat_rd = ($urandom % 4) == 0;
         if (($urandom % 4) == 0) cts_n = ~cts_n;
         if (($urandom % 4) == 0) dsr_n = ~dsr_n;
         if (($urandom % 5) == 0) cd_n  = ~cd_n;
         if (($urandom % 5) == 0) ri_n  = ~ri_n;
         tx_ser = 1'($urandom);
         rx_pin = 1'($urandom);
         step();
      end
      ctl_wr = 1'b0; stat_rd = 1'b0;
      step();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule